// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block sends a frame of 16-bit words, most significant bit first, on a single serial data line. The bit rate comes from a double-rate serial clock input. This input is sampled in the system clock domain. Each falling edge of that input moves the line to the next bit. A three-state sequencer (idle, transmitting, finished) brackets each frame. It starts a frame when a start request arrives and the programmed word count is nonzero. It leaves transmission once that many words have gone out. It then waits for the start request to drop, so one request yields exactly one frame.

Words enter through a valid/ready port into a small internal queue. The shifter pulls a new word from the queue at the start of a frame and at every word boundary except the last. If the queue is empty when a word is due, the block sends zeros for that word and raises a sticky underrun flag. Two one-cycle interrupt pulses report progress. The group pulse fires after every fourth word within a frame, and the group count restarts whenever transmission stops. The frame pulse fires once when the frame is complete.

Top module: `frame_word_tx`

## Requirements
- R1: After a synchronous active-low reset, `ser_out`, `irq_group`, `irq_frame` and `underrun` are 0 and `in_ready` is 1.
- R2: A frame starts on the clock edge at which `start` is 1 and `frame_words` is nonzero while the sequencer is idle; with `frame_words` equal to 0 no frame starts, no word is taken and no interrupt is raised.
- R3: Each word goes out MSB first over 16 bit periods. The MSB appears on the edge that loads the word. A fall of `sclk2` (sampled 1 on one clock edge and 0 on the next) shifts the line to the next bit on that second edge.
- R4: `ser_out` is 0 whenever the sequencer is not transmitting, and a frame carries exactly `frame_words` words.
- R5: After a frame, the sequencer waits while `start` stays high and returns to idle only when `start` is low, so a start request held high for any length sends one frame.
- R6: `irq_group` is a one-cycle pulse one clock after the edge that completes the 4th, 8th, 12th ... word of a frame.
- R7: The group count restarts at zero whenever transmission is not in progress, so a frame of 3 words after a frame of 6 words raises no group pulse.
- R8: `irq_frame` is a single one-cycle pulse per frame, high two clocks after the edge that completes the last word.
- R9: The input queue holds 4 words. `in_ready` is 1 while fewer than 4 are stored. A word is taken when `in_valid` and `in_ready` are both 1, and words are sent in arrival order. A word offered while `in_ready` is 0 is dropped.
- R10: If the queue is empty when a word must be loaded, that word is sent as zeros and `underrun` becomes 1. The flag stays 1 until the next frame starts, and it is cleared then unless that frame's first load also finds the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk2 | input | 1 | Double-rate serial clock, synchronous to `clk` |
| start | input | 1 | Frame start request |
| frame_words | input | 8 | Words per frame, held stable during a frame |
| in_valid | input | 1 | Input word offered |
| in_data | input | 16 | Input word |
| in_ready | output | 1 | Queue can take a word |
| ser_out | output | 1 | Serial data line |
| irq_group | output | 1 | Pulse after every fourth word |
| irq_frame | output | 1 | Pulse at frame completion |
| underrun | output | 1 | Sticky flag: a word was due while the queue was empty |

## Verification
A bit change on `ser_out` is due on the same clock edge that first samples `sclk2` low after a high, and `in_ready` reflects a push or pop on the edge that performs it. `irq_group` is due one clock after the boundary edge of every fourth word, and `irq_frame` two clocks after the final boundary edge, because the word count that is compared against `frame_words` is itself registered. The bench drives every input on falling clock edges. A behavioural reference using a queue and integer counters advances on each rising edge, and all five outputs are compared 2 ns after that edge, so every expected value is taken in the same cycle in which the design's registers change. Scenario checks then count interrupt pulses and read the flag levels once each frame has settled.

// File: rtl/ftx_pkg.sv
// Shared types for the framed serial word transmitter.
package ftx_pkg;
    // Sequencer state; the code 2'b11 is unused and decays to idle.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_XMIT   = 2'b01,
        ST_DONE   = 2'b10,
        ST_UNUSED = 2'b11
    } ftx_state_e;
endpackage

// File: rtl/ftx_fifo.sv
// Word queue with valid/ready write side and pop/empty read side.
// Assumes DEPTH is a power of two; read data is valid while not empty.
module ftx_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_pop,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]     cnt_q;
    logic              push, pop;

    assign wr_ready = (cnt_q < CW'(DEPTH));
    assign rd_empty = (cnt_q == '0);
    assign rd_data  = mem[rd_ptr_q];
    assign push     = wr_valid && wr_ready;
    assign pop      = rd_pop && !rd_empty;

    // Storage write on an accepted word.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr_q] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R9: occupancy never exceeds the depth.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R9: the reader never pops an empty queue.
    a_r9_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |-> !rd_empty);
endmodule

// File: rtl/ftx_ctrl.sv
// Frame sequencer and word counter.
// Assumes frame_words is held stable from start until the sequencer is idle again.
module ftx_ctrl
    import ftx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] frame_words,
    input  logic             word_done,
    output logic             xmit_active,
    output logic             ctrl_idle,
    output logic             running,
    output logic             enter_frame,
    output logic             last_word,
    output logic             irq_frame
);
    ftx_state_e       state_q, state_d;
    logic [CNT_W-1:0] wcnt_q;
    logic [CNT_W:0]   wcnt_inc;
    logic             match;

    assign match       = (wcnt_q == frame_words);
    assign wcnt_inc    = {1'b0, wcnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign last_word   = (wcnt_inc == {1'b0, frame_words});
    assign xmit_active = (state_q == ST_XMIT);
    assign ctrl_idle   = !xmit_active;
    assign running     = xmit_active && !match;
    assign enter_frame = (state_q == ST_IDLE) && start && !match;

    // Next-state selection for the three-state sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start && !match) state_d = ST_XMIT;
            ST_XMIT: if (match)           state_d = ST_DONE;
            ST_DONE: if (!start)          state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // State, word count and frame interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            wcnt_q    <= '0;
            irq_frame <= 1'b0;
        end else begin
            state_q   <= state_d;
            irq_frame <= xmit_active && match;
            if (!xmit_active)   wcnt_q <= '0;
            else if (word_done) wcnt_q <= wcnt_q + 1'b1;
        end
    end

    // R2: no frame starts without a request.
    a_r2_need_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> !xmit_active);
    // R5: a held request keeps the sequencer parked after a frame.
    a_r5_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && start) |=> state_q == ST_DONE);
    // R8: the frame interrupt coincides with the first finished cycle.
    a_r8_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_frame |-> state_q == ST_DONE);
endmodule

// File: rtl/ftx_ser.sv
// Bit shifter with fall detection of the double-rate clock and bit counter.
// Assumes sclk2 is synchronous to clk and stays at each level for at least one clk.
module ftx_ser #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk2,
    input  logic              xmit_active,
    input  logic              running,
    input  logic              enter_frame,
    input  logic              last_word,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              word_done,
    output logic              ser_out,
    output logic              underrun
);
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic              sclk_prev_q, tick, need_load;
    logic [BIT_W-1:0]  bcnt_q;
    logic [WORD_W-1:0] sh_q;

    assign tick      = sclk_prev_q && !sclk2;
    assign word_done = running && tick && (bcnt_q == BIT_W'(WORD_W - 1));
    assign need_load = enter_frame || (word_done && !last_word);
    assign fifo_pop  = need_load && !fifo_empty;
    assign ser_out   = xmit_active && sh_q[WORD_W-1];

    // Previous level of the serial clock for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk2;
    end

    // Bit position within the current word.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) bcnt_q <= '0;
        else if (tick)          bcnt_q <= bcnt_q + 1'b1;
    end

    // Shift register: load, clear after the final word, or shift one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                sh_q <= '0;
        else if (need_load)        sh_q <= fifo_empty ? '0 : fifo_data;
        else if (word_done)        sh_q <= '0;
        else if (running && tick)  sh_q <= sh_q << 1;
    end

    // Sticky underrun flag, cleared at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)                        underrun <= 1'b0;
        else if (need_load && fifo_empty)  underrun <= 1'b1;
        else if (enter_frame)              underrun <= 1'b0;
    end

    // R3: a detected fall inside a word moves to the next bit.
    a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !word_done && !need_load) |=> sh_q == ($past(sh_q) << 1));
    // R10: the flag persists until a frame starts.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !enter_frame) |=> underrun);
endmodule

// File: rtl/ftx_group.sv
// Four-word group counter that pulses an interrupt on each completed group.
// Assumes word_done is only asserted while transmitting.
module ftx_group #(
    parameter int GROUP_SIZE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_idle,
    input  logic word_done,
    output logic irq_group
);
    localparam int GW = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1;

    logic [GW-1:0] grp_q;
    logic          wrap;

    assign wrap = word_done && (grp_q == GW'(GROUP_SIZE - 1));

    // Group position, held at zero outside transmission, and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_idle) begin
            grp_q     <= '0;
            irq_group <= 1'b0;
        end else begin
            irq_group <= wrap;
            if (wrap)           grp_q <= '0;
            else if (word_done) grp_q <= grp_q + 1'b1;
        end
    end

    // R7: the count is cleared whenever transmission is not in progress.
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_idle |=> grp_q == '0);
    // R6: the interrupt is a single-cycle pulse.
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_group |=> !irq_group);
endmodule

// File: rtl/frame_word_tx.sv
// Framed serial word transmitter: queue, sequencer, shifter and group counter.
// Assumes sclk2 is synchronous to clk; frame_words is stable during a frame.
module frame_word_tx #(
    parameter int WORD_W     = 16,
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int GROUP_SIZE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk2,
    input  logic              start,
    input  logic [CNT_W-1:0]  frame_words,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              ser_out,
    output logic              irq_group,
    output logic              irq_frame,
    output logic              underrun
);
    logic              xmit_active, ctrl_idle, running, enter_frame, last_word;
    logic              word_done, fifo_pop, fifo_empty;
    logic [WORD_W-1:0] fifo_data;

    ftx_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(in_valid), .wr_data(in_data), .wr_ready(in_ready),
        .rd_pop(fifo_pop), .rd_data(fifo_data), .rd_empty(fifo_empty)
    );

    ftx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_words(frame_words),
        .word_done(word_done), .xmit_active(xmit_active), .ctrl_idle(ctrl_idle),
        .running(running), .enter_frame(enter_frame), .last_word(last_word),
        .irq_frame(irq_frame)
    );

    ftx_ser #(.WORD_W(WORD_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .sclk2(sclk2), .xmit_active(xmit_active),
        .running(running), .enter_frame(enter_frame), .last_word(last_word),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .word_done(word_done), .ser_out(ser_out), .underrun(underrun)
    );

    ftx_group #(.GROUP_SIZE(GROUP_SIZE)) u_group (
        .clk(clk), .rst_n(rst_n), .ctrl_idle(ctrl_idle),
        .word_done(word_done), .irq_group(irq_group)
    );

    // R4: the line is quiet whenever the sequencer is not transmitting.
    a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_idle |-> !ser_out);
endmodule

// File: tb/test_frame_word_tx.sv
`timescale 1ns/1ps
module test_frame_word_tx;
    logic        clk = 1'b0, rst_n = 1'b0, sclk2 = 1'b0, start = 1'b0, in_valid = 1'b0;
    logic [7:0]  frame_words = 8'd0;
    logic [15:0] in_data = 16'd0;
    logic        in_ready, ser_out, irq_group, irq_frame, underrun;

    frame_word_tx i_frame_word_tx (
        .clk(clk), .rst_n(rst_n), .sclk2(sclk2), .start(start),
        .frame_words(frame_words), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .ser_out(ser_out), .irq_group(irq_group),
        .irq_frame(irq_frame), .underrun(underrun)
    );

    always #5 clk = ~clk;

    // Double-rate serial clock: one level change every two system clocks.
    initial forever begin
        @(negedge clk); @(negedge clk);
        sclk2 = ~sclk2;
    end

    // Behavioural reference state.
    int          m_st, m_wcnt, m_bcnt, m_grp;
    logic [15:0] m_sh;
    logic [15:0] m_q[$];
    bit          m_irqg, m_irqf, m_under, m_sprev;

    // Reference advances on each rising edge from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_wcnt = 0; m_bcnt = 0; m_grp = 0; m_sh = '0;
            m_irqg = 0; m_irqf = 0; m_under = 0; m_sprev = 0; m_q.delete();
        end else begin
            bit tick, match, run, done, last, enter, need, rdy;
            int nst;
            tick  = m_sprev && !sclk2;
            m_sprev = sclk2;
            match = (m_wcnt == int'(frame_words));
            run   = (m_st == 1) && !match;
            done  = run && tick && (m_bcnt == 15);
            last  = (m_wcnt + 1 == int'(frame_words));
            enter = (m_st == 0) && start && !match;
            need  = enter || (done && !last);
            rdy   = (m_q.size() < 4);
            m_irqg = done && (m_grp == 3);
            m_irqf = (m_st == 1) && match;
            if (enter) m_under = 0;
            if (need) begin
                if (m_q.size() > 0) m_sh = m_q.pop_front();
                else begin m_sh = '0; m_under = 1; end
            end else if (done) m_sh = '0;
            else if (run && tick) m_sh = m_sh << 1;
            if (in_valid && rdy) m_q.push_back(in_data);
            if (m_st != 1) begin m_wcnt = 0; m_grp = 0; end
            else if (done) begin m_wcnt++; m_grp = (m_grp + 1) % 4; end
            if (!run) m_bcnt = 0; else if (tick) m_bcnt = (m_bcnt + 1) % 16;
            nst = m_st;
            case (m_st)
                0: if (enter) nst = 1;
                1: if (match) nst = 2;
                2: if (!start) nst = 0;
                default: nst = 0;
            endcase
            m_st = nst;
        end
    end

    int cmp_n = 0, cmp_bad = 0, n_grp = 0, n_frm = 0;

    task automatic cmp(string tag, logic act, logic exp);
        cmp_n++;
        if (act !== exp) begin
            cmp_bad++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    // Compare every output 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            cmp("R3 ser_out", ser_out, (m_st == 1) ? m_sh[15] : 1'b0);
            cmp("R9 in_ready", in_ready, m_q.size() < 4);
            cmp("R6 irq_group", irq_group, m_irqg);
            cmp("R8 irq_frame", irq_frame, m_irqf);
            cmp("R10 underrun", underrun, m_under);
            if (irq_group) n_grp++;
            if (irq_frame) n_frm++;
        end
    end

    int chk_n = 0, chk_bad = 0, wd_bad = 0, seq = 0;
    bit finished = 0;

    task automatic chk(string tag, int act, int exp);
        chk_n++;
        if (act != exp) begin
            chk_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_word();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'((seq * 40503) ^ 16'hA55A);
        seq++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_frame(int n, int npush, int hold);
        int pre;
        pre = (npush < 4) ? npush : 4;
        @(negedge clk);
        frame_words = 8'(n);
        for (int i = 0; i < pre; i++) push_word();
        fork
            begin
                @(negedge clk); start = 1'b1;
                repeat (hold) @(negedge clk);
                start = 1'b0;
            end
            begin
                for (int i = pre; i < npush; i++) push_word();
            end
        join
        repeat (n * 64 + 40) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 cmp_n + chk_n + wd_bad, cmp_bad + chk_bad + wd_bad);
    endtask

    initial begin
        int g0, f0;
        repeat (4) @(negedge clk);
        chk("R1 ser_out reset", ser_out, 0);
        chk("R1 in_ready reset", in_ready, 1);
        chk("R1 irq reset", irq_group | irq_frame, 0);
        chk("R1 underrun reset", underrun, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Eight-word frame: two group pulses, one frame pulse.
        g0 = n_grp; f0 = n_frm;
        run_frame(8, 8, 1);
        chk("R6 groups in 8 words", n_grp - g0, 2);
        chk("R8 frame pulses", n_frm - f0, 1);
        chk("R4 line low after frame", ser_out, 0);
        chk("R10 no underrun when fed", underrun, 0);

        // Start held far beyond the frame: still one frame.
        f0 = n_frm;
        run_frame(2, 2, 300);
        chk("R5 held start sends one frame", n_frm - f0, 1);
        chk("R5 line low after held frame", ser_out, 0);

        // Six words then three: group count must restart.
        g0 = n_grp;
        run_frame(6, 6, 1);
        chk("R7 groups in 6 words", n_grp - g0, 1);
        g0 = n_grp;
        run_frame(3, 3, 1);
        chk("R7 no group in following 3 words", n_grp - g0, 0);

        // Starved frame then a fed frame.
        run_frame(2, 1, 1);
        chk("R10 underrun set", underrun, 1);
        run_frame(1, 1, 1);
        chk("R10 underrun cleared by new frame", underrun, 0);

        // Zero-length request does nothing.
        f0 = n_frm; g0 = n_grp;
        run_frame(0, 0, 1);
        chk("R2 no frame for zero words", n_frm - f0, 0);
        chk("R2 line stays low", ser_out, 0);

        // Fill the queue, offer one word while full, then drain it.
        for (int i = 0; i < 4; i++) push_word();
        @(negedge clk);
        chk("R9 ready low when full", in_ready, 0);
        in_valid = 1'b1; in_data = 16'hDEAD;
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        g0 = n_grp;
        run_frame(4, 0, 1);
        chk("R6 group after 4 words", n_grp - g0, 1);
        chk("R9 ready after drain", in_ready, 1);
        chk("R10 no underrun on drained queue", underrun, 0);

        finished = 1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            wd_bad = 1;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule